// File: doc/BRIEF.md
# Quadrature-Encoder VFO Tuning Controller

This block turns the two square-wave channels of a mechanical rotary encoder into frequency changes for a synthesized oscillator. Each valid Gray-code transition counts as one step up or one step down. The selected mode routes the step to one of three targets:

- the main frequency, with a selectable coarse step;
- a receive-offset trim (RIT), with a fixed 10 Hz step and a ±10 kHz bound;
- a 1 Hz calibration trim of the main frequency, during which the displayed value stays frozen.

Two switchable offsets, each with its own sign, are added on top. A bank of channel registers can store the tuning state and bring it back. The result is a registered frequency in Hz. A separate stage converts this value into a synthesizer tuning word.

The encoder inputs are assumed to be debounced already and synchronous to `clk`. The save, recall and RIT-toggle inputs are single-cycle strobes.

Top module: `vfo_tune_ctrl`

## Requirements
- R1: The encoder code {enc_a,enc_b} is read in the order 10, 11, 01, 00, 10. A move one place forward in this order is one up step. A move one place back is one down step. A code that does not change gives no step.
- R2: A transition that changes both encoder bits at once gives no step and changes no register. Later steps are measured from the new code.
- R3: With mode = 00, each step changes the main frequency by 10 Hz (step_sel 00), 100 Hz (01), or 1 kHz (10 or 11). The main frequency saturates at FREQ_MIN and at FREQ_MAX. With mode = 11, steps are ignored.
- R4: With mode = 01, each step changes the RIT value by 10 Hz. The RIT value saturates at +10000 and at -10000 and never wraps.
- R5: With mode = 10, each step changes the main frequency by 1 Hz, within the same limits as R3. disp_freq holds its value while mode = 10. In every other mode, disp_freq follows the main frequency one cycle late.
- R6: A rit_tgl strobe inverts the RIT enable. The RIT value is added to the output only while the RIT enable is set.
- R7: Each offset is added to the output when its enable is high. It is added when its neg bit is 0 and subtracted when its neg bit is 1.
- R8: freq_out = main + RIT (if enabled) ± the enabled offsets. freq_out is registered one cycle after the state or inputs it depends on. A negative sum gives 0.
- R9: A save strobe stores the main frequency, the RIT value and the RIT enable into channel mem_sel. A recall strobe loads all three back from that channel. Recall takes priority over an encoder step in the same cycle. Save takes priority over recall.
- R10: After reset, the main frequency and every channel hold RESET_FREQ, RIT is 0 and disabled, and disp_freq equals RESET_FREQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder channel A |
| enc_b | input | 1 | Encoder channel B |
| mode | input | 2 | 00 main, 01 RIT, 10 calibrate, 11 hold |
| step_sel | input | 2 | Main-mode step size select |
| rit_tgl | input | 1 | Strobe that inverts the RIT enable |
| ofs1_en | input | 1 | Offset 1 enable |
| ofs1_neg | input | 1 | Offset 1 subtract |
| ofs1_val | input | OFS_W | Offset 1 magnitude in Hz |
| ofs2_en | input | 1 | Offset 2 enable |
| ofs2_neg | input | 1 | Offset 2 subtract |
| ofs2_val | input | OFS_W | Offset 2 magnitude in Hz |
| mem_sel | input | $clog2(CHANNELS) | Channel index for save and recall |
| save | input | 1 | Store strobe |
| recall | input | 1 | Load strobe |
| freq_out | output | 32 | Effective frequency in Hz |
| disp_freq | output | 32 | Frequency for display |

## Verification
Each stimulus is applied half a period before a rising edge. An encoder move, a strobe or a mode change updates the tuning registers at that first edge. freq_out and disp_freq reflect the update at the next edge, so each result is due two edges after the stimulus. The bench samples every result at the falling edge after that second rising edge. Strobes are held for exactly one cycle. The expected value comes from a model updated by the requirement rules. The run covers directed clamp, freeze, saturation and priority cases, followed by a seeded random mix of moves, mode switches, offsets and channel operations.

// File: rtl/vfo_pkg.sv
// Shared widths and types for the encoder tuning controller.
package vfo_pkg;
    localparam int FREQ_W = 32;
    localparam int RIT_W  = 16;

    typedef enum logic [1:0] {
        MODE_MAIN = 2'b00,
        MODE_RIT  = 2'b01,
        MODE_CAL  = 2'b10,
        MODE_HOLD = 2'b11
    } tune_mode_e;

    // One complete set of stored tuning state.
    typedef struct packed {
        logic [FREQ_W-1:0]        main;
        logic signed [RIT_W-1:0]  rit;
        logic                     rit_en;
    } tune_set_t;
endpackage

// File: rtl/vfo_quad_dec.sv
// Quadrature decoder: compares the present encoder code with the code seen
// at the previous edge and flags one up or one down step.
// Assumes the inputs are debounced and synchronous to clk.
// A double-bit jump is dropped.
module vfo_quad_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    output logic step_up,
    output logic step_dn
);
    logic [1:0] ab_q;
    logic       primed_q;
    logic [1:0] delta;

    // Position of a code along the clockwise sequence.
    function automatic logic [1:0] gray_pos(input logic [1:0] ab);
        case (ab)
            2'b10:   return 2'd0;
            2'b11:   return 2'd1;
            2'b01:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Remember the last code; primed marks that a valid reference exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ab_q     <= 2'b00;
            primed_q <= 1'b0;
        end else begin
            ab_q     <= {enc_a, enc_b};
            primed_q <= 1'b1;
        end
    end

    // Forward one position is up, back one is down, two apart is illegal.
    always_comb begin
        delta   = gray_pos({enc_a, enc_b}) - gray_pos(ab_q);
        step_up = primed_q && (delta == 2'd1);
        step_dn = primed_q && (delta == 2'd3);
    end

    a_r1_single_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    a_r2_illegal_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && (({enc_a, enc_b} ^ ab_q) == 2'b11)) |-> !(step_up || step_dn));
endmodule

// File: rtl/vfo_tune_regs.sv
// Tuning registers: applies decoded steps to the main frequency or RIT
// according to the mode. Holds the RIT enable and the display copy.
// A load from a memory channel overrides any step in the same cycle.
module vfo_tune_regs #(
    parameter int unsigned RESET_FREQ = 7_000_000,
    parameter int unsigned FREQ_MIN   = 100_000,
    parameter int unsigned FREQ_MAX   = 60_000_000,
    parameter int          RIT_LIM    = 10_000,
    parameter int          RIT_STEP   = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step_up,
    input  logic                       step_dn,
    input  vfo_pkg::tune_mode_e        mode_i,
    input  logic [1:0]                 step_sel,
    input  logic                       rit_tgl,
    input  logic                       load_i,
    input  vfo_pkg::tune_set_t         load_val,
    output vfo_pkg::tune_set_t         cur_o,
    output logic [vfo_pkg::FREQ_W-1:0] disp_o
);
    import vfo_pkg::*;

    localparam logic [FREQ_W-1:0]       F_HI   = FREQ_W'(FREQ_MAX);
    localparam logic [FREQ_W-1:0]       F_LO   = FREQ_W'(FREQ_MIN);
    localparam logic [FREQ_W-1:0]       F_RST  = FREQ_W'(RESET_FREQ);
    localparam logic signed [RIT_W-1:0] R_HI   = RIT_W'(RIT_LIM);
    localparam logic signed [RIT_W-1:0] R_LO   = RIT_W'(-RIT_LIM);
    localparam logic signed [RIT_W-1:0] R_STEP = RIT_W'(RIT_STEP);

    tune_set_t         cur_q, cur_nx;
    logic [FREQ_W-1:0] amt;
    logic [FREQ_W-1:0] disp_q;

    // Step size: 1 Hz when calibrating, otherwise chosen by step_sel.
    always_comb begin
        if (mode_i == MODE_CAL) amt = FREQ_W'(1);
        else begin
            case (step_sel)
                2'b00:   amt = FREQ_W'(10);
                2'b01:   amt = FREQ_W'(100);
                default: amt = FREQ_W'(1000);
            endcase
        end
    end

    // Next-state: load, else a clamped step on the selected register.
    always_comb begin
        cur_nx = cur_q;
        if (load_i) begin
            cur_nx = load_val;
        end else begin
            if (rit_tgl) cur_nx.rit_en = !cur_q.rit_en;
            if (mode_i == MODE_MAIN || mode_i == MODE_CAL) begin
                if (step_up)
                    cur_nx.main = (cur_q.main > F_HI - amt) ? F_HI : cur_q.main + amt;
                else if (step_dn)
                    cur_nx.main = (cur_q.main < F_LO + amt) ? F_LO : cur_q.main - amt;
            end else if (mode_i == MODE_RIT) begin
                if (step_up)
                    cur_nx.rit = (cur_q.rit > R_HI - R_STEP) ? R_HI : cur_q.rit + R_STEP;
                else if (step_dn)
                    cur_nx.rit = (cur_q.rit < R_LO + R_STEP) ? R_LO : cur_q.rit - R_STEP;
            end
        end
    end

    // State register and the display copy that freezes in calibration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '{main: F_RST, rit: '0, rit_en: 1'b0};
            disp_q <= F_RST;
        end else begin
            cur_q <= cur_nx;
            if (mode_i != MODE_CAL) disp_q <= cur_q.main;
        end
    end

    assign cur_o  = cur_q;
    assign disp_o = disp_q;

    a_r3_main_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.main >= F_LO) && (cur_q.main <= F_HI));

    a_r4_rit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.rit >= R_LO) && (cur_q.rit <= R_HI));

    a_r5_disp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_CAL) |=> $stable(disp_q));

    a_r6_rit_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (rit_tgl && !load_i) |=> (cur_q.rit_en != $past(cur_q.rit_en)));

    a_r3_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_HOLD && !load_i) |=> ($stable(cur_q.main) && $stable(cur_q.rit)));
endmodule

// File: rtl/vfo_mem_bank.sv
// Channel memory: one register-file word per channel holding a full tuning
// set. The write is synchronous and the read is combinational.
// Every word resets to the power-on tuning state.
module vfo_mem_bank #(
    parameter int          CHANNELS   = 16,
    parameter int unsigned RESET_FREQ = 7_000_000,
    localparam int         AW         = $clog2(CHANNELS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [AW-1:0]      addr_i,
    input  vfo_pkg::tune_set_t wdata_i,
    output vfo_pkg::tune_set_t rdata_o
);
    import vfo_pkg::*;

    tune_set_t mem_q [CHANNELS];

    // Each word is written only when addressed by a save strobe.
    for (genvar g = 0; g < CHANNELS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '{main: FREQ_W'(RESET_FREQ), rit: '0, rit_en: 1'b0};
            else if (wr_i && addr_i == AW'(g))
                mem_q[g] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];

    a_r9_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mem_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/vfo_freq_sum.sv
// Output adder: main plus enabled RIT plus each enabled signed offset.
// The sum saturates to the unsigned output range and is registered once.
module vfo_freq_sum #(
    parameter int N_OFS = 2,
    parameter int OFS_W = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  vfo_pkg::tune_set_t         set_i,
    input  logic [N_OFS-1:0]           ofs_en,
    input  logic [N_OFS-1:0]           ofs_neg,
    input  logic [N_OFS-1:0][OFS_W-1:0] ofs_val,
    output logic [vfo_pkg::FREQ_W-1:0] freq_o
);
    import vfo_pkg::*;

    localparam int SW = FREQ_W + $clog2(N_OFS + 2) + 1;

    logic signed [SW-1:0] acc;
    logic [FREQ_W-1:0]    sat;

    // Signed accumulation of all contributions, then saturate.
    always_comb begin
        acc = signed'({{(SW-FREQ_W){1'b0}}, set_i.main});
        if (set_i.rit_en)
            acc = acc + signed'({{(SW-RIT_W){set_i.rit[RIT_W-1]}}, set_i.rit});
        for (int i = 0; i < N_OFS; i++) begin
            if (ofs_en[i]) begin
                if (ofs_neg[i]) acc = acc - signed'({{(SW-OFS_W){1'b0}}, ofs_val[i]});
                else            acc = acc + signed'({{(SW-OFS_W){1'b0}}, ofs_val[i]});
            end
        end
        if (acc < 0)
            sat = '0;
        else if (acc[SW-1:FREQ_W] != '0)
            sat = '1;
        else
            sat = acc[FREQ_W-1:0];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) freq_o <= '0;
        else        freq_o <= sat;
    end
endmodule

// File: rtl/vfo_tune_ctrl.sv
// Top of the encoder tuning controller: decoder, tuning registers, channel
// memory and output adder. Assumes debounced synchronous inputs and
// single-cycle save, recall and rit_tgl strobes.
module vfo_tune_ctrl #(
    parameter int          CHANNELS   = 16,
    parameter int          OFS_W      = 24,
    parameter int unsigned RESET_FREQ = 7_000_000,
    parameter int unsigned FREQ_MIN   = 100_000,
    parameter int unsigned FREQ_MAX   = 60_000_000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enc_a,
    input  logic                        enc_b,
    input  logic [1:0]                  mode,
    input  logic [1:0]                  step_sel,
    input  logic                        rit_tgl,
    input  logic                        ofs1_en,
    input  logic                        ofs1_neg,
    input  logic [OFS_W-1:0]            ofs1_val,
    input  logic                        ofs2_en,
    input  logic                        ofs2_neg,
    input  logic [OFS_W-1:0]            ofs2_val,
    input  logic [$clog2(CHANNELS)-1:0] mem_sel,
    input  logic                        save,
    input  logic                        recall,
    output logic [31:0]                 freq_out,
    output logic [31:0]                 disp_freq
);
    import vfo_pkg::*;

    logic      up, dn, load;
    tune_set_t cur_set, mem_rd;

    // Save wins over recall.
    assign load = recall && !save;

    vfo_quad_dec i_dec (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .step_up(up), .step_dn(dn)
    );

    vfo_tune_regs #(
        .RESET_FREQ(RESET_FREQ), .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .step_up(up), .step_dn(dn),
        .mode_i(tune_mode_e'(mode)), .step_sel(step_sel), .rit_tgl(rit_tgl),
        .load_i(load), .load_val(mem_rd), .cur_o(cur_set), .disp_o(disp_freq)
    );

    vfo_mem_bank #(.CHANNELS(CHANNELS), .RESET_FREQ(RESET_FREQ)) i_mem (
        .clk(clk), .rst_n(rst_n), .wr_i(save), .addr_i(mem_sel),
        .wdata_i(cur_set), .rdata_o(mem_rd)
    );

    vfo_freq_sum #(.N_OFS(2), .OFS_W(OFS_W)) i_sum (
        .clk(clk), .rst_n(rst_n), .set_i(cur_set),
        .ofs_en({ofs2_en, ofs1_en}), .ofs_neg({ofs2_neg, ofs1_neg}),
        .ofs_val({ofs2_val, ofs1_val}), .freq_o(freq_out)
    );

    a_r9_recall_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_set == $past(mem_rd)));
endmodule

// File: tb/test_vfo_tune_ctrl.sv
module test_vfo_tune_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int F_RST = 7_000_000;
    localparam int F_MIN = 6_995_000;
    localparam int F_MAX = 7_005_000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enc_a = 1'b0, enc_b = 1'b0;
    logic [1:0] mode = 2'b00, step_sel = 2'b00;
    logic rit_tgl = 1'b0, save = 1'b0, recall = 1'b0;
    logic ofs1_en = 1'b0, ofs1_neg = 1'b0, ofs2_en = 1'b0, ofs2_neg = 1'b0;
    logic [23:0] ofs1_val = '0, ofs2_val = '0;
    logic [3:0] mem_sel = '0;
    logic [31:0] freq_out, disp_freq;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    // Model state.
    longint m_main, m_rit, m_disp;
    bit m_en;
    longint mem_main [16];
    longint mem_rit [16];
    bit mem_en [16];
    int pos = 3;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfo_tune_ctrl #(.RESET_FREQ(F_RST), .FREQ_MIN(F_MIN), .FREQ_MAX(F_MAX)) i_vfo_tune_ctrl (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .mode(mode),
        .step_sel(step_sel), .rit_tgl(rit_tgl), .ofs1_en(ofs1_en), .ofs1_neg(ofs1_neg),
        .ofs1_val(ofs1_val), .ofs2_en(ofs2_en), .ofs2_neg(ofs2_neg), .ofs2_val(ofs2_val),
        .mem_sel(mem_sel), .save(save), .recall(recall),
        .freq_out(freq_out), .disp_freq(disp_freq)
    );

    function automatic logic [1:0] code_of(int p);
        case (p & 3)
            0: return 2'b10;
            1: return 2'b11;
            2: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic longint clampl(longint v, longint lo, longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic longint exp_freq();
        longint s = m_main;
        if (m_en) s += m_rit;
        if (ofs1_en) s += ofs1_neg ? -longint'(ofs1_val) : longint'(ofs1_val);
        if (ofs2_en) s += ofs2_neg ? -longint'(ofs2_val) : longint'(ofs2_val);
        return clampl(s, 0, 64'hFFFF_FFFF);
    endfunction

    task automatic check(string req, longint act, longint exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Two edges after inputs set at a negedge; strobes last one cycle.
    task automatic run_op(string req);
        @(posedge clk);
        @(negedge clk);
        save = 1'b0; recall = 1'b0; rit_tgl = 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (mode != 2'b10) m_disp = m_main;
        check(req, freq_out, exp_freq(), "freq_out");
        check(req, disp_freq, m_disp, "disp_freq");
    endtask

    // dir: 1 up, -1 down, 2 illegal double-bit jump.
    task automatic enc_move(int dir, string req);
        longint amt;
        pos = (dir == 2) ? pos + 2 : pos + dir;
        {enc_a, enc_b} = code_of(pos);
        amt = (step_sel == 2'b00) ? 10 : (step_sel == 2'b01) ? 100 : 1000;
        if (dir != 2) begin
            case (mode)
                2'b00: m_main = clampl(m_main + dir * amt, F_MIN, F_MAX);
                2'b01: m_rit  = clampl(m_rit + dir * 10, -10000, 10000);
                2'b10: m_main = clampl(m_main + dir, F_MIN, F_MAX);
                default: ;
            endcase
        end
        run_op(req);
    endtask

    task automatic set_mode(logic [1:0] m, string req);
        mode = m;
        run_op(req);
    endtask

    task automatic toggle_rit(string req);
        rit_tgl = 1'b1;
        m_en = !m_en;
        run_op(req);
    endtask

    task automatic do_save(int ch, string req);
        mem_sel = 4'(ch); save = 1'b1;
        mem_main[ch] = m_main; mem_rit[ch] = m_rit; mem_en[ch] = m_en;
        run_op(req);
    endtask

    task automatic do_recall(int ch, string req);
        mem_sel = 4'(ch); recall = 1'b1;
        m_main = mem_main[ch]; m_rit = mem_rit[ch]; m_en = mem_en[ch];
        run_op(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_main = F_RST; m_rit = 0; m_en = 0; m_disp = F_RST;
        for (int i = 0; i < 16; i++) begin
            mem_main[i] = F_RST; mem_rit[i] = 0; mem_en[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        check("R10", freq_out, F_RST, "reset freq_out");
        check("R10", disp_freq, F_RST, "reset disp_freq");

        // R1/R3: direction and step sizes in main mode.
        step_sel = 2'b00; enc_move(1, "R1");
        check("R3", freq_out, F_RST + 10, "10 Hz step");
        step_sel = 2'b01; enc_move(-1, "R1");
        check("R3", freq_out, F_RST - 90, "100 Hz down step");
        step_sel = 2'b10; enc_move(1, "R3");
        step_sel = 2'b11; enc_move(1, "R3");
        check("R3", freq_out, F_RST + 1910, "1 kHz steps");
        for (int i = 0; i < 10; i++) enc_move(1, "R3");
        check("R3", freq_out, F_MAX, "upper clamp");
        for (int i = 0; i < 15; i++) enc_move(-1, "R3");
        check("R3", freq_out, F_MIN, "lower clamp");
        set_mode(2'b11, "R3");
        enc_move(1, "R3"); enc_move(1, "R3");
        check("R3", freq_out, F_MIN, "hold mode ignores steps");

        // R2: illegal jump.
        set_mode(2'b00, "R2"); step_sel = 2'b00;
        enc_move(2, "R2");
        check("R2", freq_out, F_MIN, "illegal jump ignored");
        enc_move(1, "R2");
        check("R2", freq_out, F_MIN + 10, "step after jump");

        // R4/R6: RIT clamps and enable.
        set_mode(2'b01, "R4");
        enc_move(1, "R6");
        check("R6", freq_out, F_MIN + 10, "RIT disabled has no effect");
        toggle_rit("R6");
        check("R6", freq_out, F_MIN + 20, "RIT enabled adds");
        for (int i = 0; i < 1005; i++) enc_move(1, "R4");
        check("R4", freq_out, F_MIN + 10 + 10000, "RIT upper clamp");
        for (int i = 0; i < 2010; i++) enc_move(-1, "R4");
        check("R4", freq_out, F_MIN + 10 - 10000, "RIT lower clamp");
        toggle_rit("R6");

        // R5: calibration freezes display.
        set_mode(2'b10, "R5");
        enc_move(1, "R5"); enc_move(1, "R5"); enc_move(-1, "R5"); enc_move(1, "R5");
        check("R5", disp_freq, F_MIN + 10, "display frozen");
        check("R5", freq_out, F_MIN + 12, "1 Hz steps");
        set_mode(2'b00, "R5");
        check("R5", disp_freq, F_MIN + 12, "display resumes");

        // R7/R8: offsets and negative saturation.
        ofs1_val = 24'd1500; ofs1_en = 1'b1; run_op("R7");
        ofs2_val = 24'd700; ofs2_en = 1'b1; ofs2_neg = 1'b1; run_op("R7");
        check("R7", freq_out, F_MIN + 12 + 800, "two offsets");
        ofs1_val = 24'd16_000_000; ofs1_neg = 1'b1; run_op("R8");
        check("R8", freq_out, 0, "negative sum saturates");
        ofs1_en = 1'b0; ofs2_en = 1'b0; run_op("R8");

        // R9: save, recall, priorities.
        do_save(3, "R9");
        for (int i = 0; i < 4; i++) enc_move(1, "R9");
        do_recall(3, "R9");
        check("R9", freq_out, F_MIN + 12, "recall restores");
        recall = 1'b1; mem_sel = 4'd5;
        pos = pos + 1; {enc_a, enc_b} = code_of(pos);
        m_main = mem_main[5]; m_rit = mem_rit[5]; m_en = mem_en[5];
        run_op("R9");
        check("R9", freq_out, F_RST, "recall beats step");
        enc_move(1, "R9");
        save = 1'b1; recall = 1'b1; mem_sel = 4'd7;
        mem_main[7] = m_main; mem_rit[7] = m_rit; mem_en[7] = m_en;
        run_op("R9");
        check("R9", freq_out, F_RST + 10, "save beats recall");

        // Random mix.
        for (int n = 0; n < 1500; n++) begin
            int r = $urandom_range(0, 9);
            case (r)
                0, 1, 2, 3, 4: begin
                    int d = $urandom_range(0, 7);
                    enc_move((d == 0) ? 2 : (d < 4) ? 1 : -1, "R1");
                end
                5: set_mode(2'($urandom_range(0, 3)), "R5");
                6: begin step_sel = 2'($urandom_range(0, 3)); run_op("R3"); end
                7: toggle_rit("R6");
                8: begin
                    ofs1_en = 1'($urandom); ofs1_neg = 1'($urandom);
                    ofs2_en = 1'($urandom); ofs2_neg = 1'($urandom);
                    ofs1_val = 24'($urandom_range(0, 9_000_000));
                    ofs2_val = 24'($urandom_range(0, 20_000));
                    run_op("R8");
                end
                default: begin
                    if ($urandom_range(0, 1) == 0) do_save($urandom_range(0, 15), "R9");
                    else do_recall($urandom_range(0, 15), "R9");
                end
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule